// File: doc/BRIEF.md
# JTAG Debug Port Scan Target

This block is the target side of a debug link reached through a standard four-wire test access port. The test clock is the block's only clock. A 16-state TAP controller steers a 4-bit instruction register and a data-register path. The path is 32 bits for the identification code, 35 bits for the access and abort registers, and a 1-bit bypass for any other code. One access scan carries a 3-bit header and a 32-bit word. The header names a debug-port register or an access-port register and the transfer direction. On the way out, the same three bit positions return an acknowledge code.

Results are posted one scan late. The word captured at the start of a scan is the result of the last completed read. A dedicated read-buffer address returns that word again with no side effect. Behind the debug port sits a simple access port: a register file addressed through a bank field. It stays busy for a configurable number of test-clock cycles after each accepted request. A scan that starts while it is busy returns WAIT, and its own request is dropped. Sticky overrun and error flags record protocol trouble, and they block access-port traffic until a host clears them. An abort scan cancels an access that is still in flight.

Top module: `jdp_port`

## Requirements
- R1: Five test clocks with `tms` high put the controller in Test-Logic-Reset, which selects the identification instruction (code 0xE). A data scan then returns `IDCODE_VAL`, least significant bit first.
- R2: The instruction register is 4 bits and captures 0b0001 for shift-out. Codes 0x8 (abort), 0xA (debug-port access), 0xB (access-port access) and 0xE (identification) are decoded. Every other code selects a 1-bit bypass register that captures 0.
- R3: Access and abort scans are 35 bits, header first. In the shifted-in header, bit 0 is the direction (1 = read) and bits [2:1] are the register address A[3:2]. The captured header is the acknowledge: 0b010 means OK and 0b001 means WAIT. The 32 data bits follow, least significant bit first, and a request takes effect at Update-DR.
- R4: The captured data is the result of the latest completed read, not the read being requested. A read of debug-port address 3 (read buffer) returns that word and leaves it unchanged. A read of debug-port address 0 posts zero.
- R5: Debug-port address 1 (control/status) reads bits [31:28] from `pwr_ack`, bit 0 as the overrun-detect enable, bit 1 as the sticky overrun flag and bit 5 as the sticky error flag. All other bits read 0. A write sets bit 0, and writing 1 to bit 1 or bit 5 clears that flag.
- R6: Debug-port address 2 (select) stores a bank in bits [7:4] and an access-port number in bits [31:24]. All other bits read 0. An access-port request addresses register bank*4 + A[3:2], modulo 2^`AP_AW`.
- R7: An accepted access-port request keeps the port busy for `AP_LAT` test clocks. A capture of an access or abort register while it is busy returns WAIT. A read result is posted when the busy time ends.
- R8: A debug-port or access-port request whose scan captured WAIT is dropped. If overrun detection is enabled, it also sets the sticky overrun flag.
- R9: While either sticky flag is set, access-port requests are discarded: no register is written, no busy period starts and the posted word is unchanged.
- R10: An access-port request with a non-zero access-port number sets the sticky error flag. A read of that kind posts zero.
- R11: An abort scan with data value 1 ends the outstanding access: the next capture returns OK and the pending read result is never posted. Any other abort value has no effect.
- R12: Test-Logic-Reset clears both sticky flags, the overrun-detect enable and the select register.
- R13: `tdo` is 0 except in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; every register changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data into the selected shift register |
| pwr_ack | input | 4 | Power acknowledges shown in control/status bits [31:28] |
| tdo | output | 1 | Serial data out of the selected shift register |

## Verification
A wrong busy count or acknowledge decision shows on the next scan of an access register, as a WAIT where OK was due or the reverse, and that header is the first three bits shifted out. A wrong posted word or a request that was not dropped shows one scan later, in the data of the following capture or in a read-buffer read. Sticky-flag and select mistakes show when control/status or select is read back. Most of them also show in the next access-port read, because that read then posts the wrong word or none at all.

// File: rtl/jdp_pkg.sv
package jdp_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {DR_BYP, DR_ID, DR_ACC} dr_kind_t;

  localparam int IR_W   = 4;
  localparam int HDR_W  = 3;
  localparam int WORD_W = 32;
  localparam int ACC_W  = HDR_W + WORD_W;

  localparam logic [IR_W-1:0] IR_ABORT  = 4'h8;
  localparam logic [IR_W-1:0] IR_DPACC  = 4'hA;
  localparam logic [IR_W-1:0] IR_APACC  = 4'hB;
  localparam logic [IR_W-1:0] IR_IDCODE = 4'hE;
  localparam logic [IR_W-1:0] IR_CAPVAL = 4'b0001;

  localparam logic [HDR_W-1:0] ACK_OK   = 3'b010;
  localparam logic [HDR_W-1:0] ACK_WAIT = 3'b001;

endpackage

// File: rtl/jdp_tap.sv
module jdp_tap
  import jdp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tms,
  input  logic            tdi,
  output tap_state_t      state,
  output logic [IR_W-1:0] ir,
  output logic            ir_tdo
);

  tap_state_t      nxt;
  logic [IR_W-1:0] ir_sr;

  always_comb begin
    case (state)
      TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
      TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_SHF_DR: nxt = tms ? TS_EX1_DR : TS_SHF_DR;
      TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SHF_DR;
      TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_SHF_IR: nxt = tms ? TS_EX1_IR : TS_SHF_IR;
      TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SHF_IR;
      default:   nxt = tms ? TS_SEL_DR : TS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TS_RESET;
      ir    <= IR_IDCODE;
      ir_sr <= '0;
    end else begin
      state <= nxt;
      case (state)
        TS_RESET:  ir    <= IR_IDCODE;
        TS_CAP_IR: ir_sr <= IR_CAPVAL;
        TS_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        TS_UPD_IR: ir    <= ir_sr;
        default: ;
      endcase
    end
  end

  assign ir_tdo = ir_sr[0];

endmodule

// File: rtl/jdp_shift.sv
module jdp_shift
  import jdp_pkg::*;
#(
  parameter int W    = 35,
  parameter int ID_W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic         shf,
  input  dr_kind_t     kind,
  input  logic [W-1:0] cap_val,
  input  logic         tdi,
  output logic [W-1:0] sr
);

  logic [W-1:0] sh_next;

  always_comb begin
    sh_next = '0;
    case (kind)
      DR_ACC:  sh_next = {tdi, sr[W-1:1]};
      DR_ID:   sh_next[ID_W-1:0] = {tdi, sr[ID_W-1:1]};
      default: sh_next[0] = tdi;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      sr <= '0;
    else if (cap) sr <= cap_val;
    else if (shf) sr <= sh_next;
  end

endmodule

// File: rtl/jdp_ap.sv
module jdp_ap #(
  parameter int AW  = 6,
  parameter int DW  = 32,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  input  logic          abort,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          rd_q;

  // storage port without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (start) begin
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      rd_q <= 1'b0;
    end else if (abort) begin
      cnt  <= '0;
    end else if (start) begin
      cnt  <= CW'(LAT);
      rd_q <= !we;
    end else if (cnt != '0) begin
      cnt  <= cnt - CW'(1);
    end
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1)) && rd_q && !abort && !start;

endmodule

// File: rtl/jdp_port.sv
module jdp_port
  import jdp_pkg::*;
#(
  parameter logic [31:0] IDCODE_VAL = 32'h4C6B_2A11,
  parameter int          AP_AW      = 6,
  parameter int          AP_LAT     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  input  logic       tdi,
  input  logic [3:0] pwr_ack,
  output logic       tdo
);

  localparam int IDX_FULL = 6;

  tap_state_t         tap_state;
  logic [IR_W-1:0]    ir_q;
  logic               ir_tdo;
  dr_kind_t           kind;
  logic [ACC_W-1:0]   dr_sr;
  logic [ACC_W-1:0]   cap_val;
  logic [WORD_W-1:0]  post_q;
  logic               ap_busy, ap_done;
  logic [WORD_W-1:0]  ap_rdata;
  logic               wait_q;
  logic               oren_q, orun_q, err_q;
  logic [3:0]         bank_q;
  logic [7:0]         apn_q;

  jdp_tap u_tap (
    .clk(clk), .rst(rst), .tms(tms), .tdi(tdi),
    .state(tap_state), .ir(ir_q), .ir_tdo(ir_tdo)
  );

  always_comb begin
    case (ir_q)
      IR_IDCODE:                    kind = DR_ID;
      IR_ABORT, IR_DPACC, IR_APACC: kind = DR_ACC;
      default:                      kind = DR_BYP;
    endcase
  end

  always_comb begin
    cap_val = '0;
    case (kind)
      DR_ID:   cap_val[WORD_W-1:0] = IDCODE_VAL;
      DR_ACC:  cap_val = {post_q, ap_busy ? ACK_WAIT : ACK_OK};
      default: ;
    endcase
  end

  jdp_shift #(.W(ACC_W), .ID_W(WORD_W)) u_dr (
    .clk(clk), .rst(rst),
    .cap(tap_state == TS_CAP_DR), .shf(tap_state == TS_SHF_DR),
    .kind(kind), .cap_val(cap_val), .tdi(tdi), .sr(dr_sr)
  );

  // request fields as they stand at Update-DR
  logic              upd, rnw, is_dp, is_ap, is_ab, sticky;
  logic              acc_ok, ap_go, ap_miss, abort_go;
  logic [1:0]        reg_a;
  logic [WORD_W-1:0] wd;
  logic [IDX_FULL-1:0] idx_full;
  logic [AP_AW-1:0]  ap_idx;
  logic [WORD_W-1:0] ctrl_rd, sel_rd;

  assign upd      = (tap_state == TS_UPD_DR) && (kind == DR_ACC);
  assign rnw      = dr_sr[0];
  assign reg_a    = dr_sr[2:1];
  assign wd       = dr_sr[ACC_W-1:HDR_W];
  assign is_dp    = (ir_q == IR_DPACC);
  assign is_ap    = (ir_q == IR_APACC);
  assign is_ab    = (ir_q == IR_ABORT);
  assign sticky   = orun_q || err_q;
  assign acc_ok   = upd && (is_dp || is_ap) && !wait_q;
  assign ap_go    = acc_ok && is_ap && !sticky && (apn_q == 8'd0);
  assign ap_miss  = acc_ok && is_ap && !sticky && (apn_q != 8'd0);
  assign abort_go = upd && is_ab && (wd == 32'd1);
  assign idx_full = {bank_q, reg_a};
  assign ap_idx   = idx_full[AP_AW-1:0];
  assign ctrl_rd  = {pwr_ack, 22'd0, err_q, 3'd0, orun_q, oren_q};
  assign sel_rd   = {apn_q, 16'd0, bank_q, 4'd0};

  jdp_ap #(.AW(AP_AW), .DW(WORD_W), .LAT(AP_LAT)) u_ap (
    .clk(clk), .rst(rst), .start(ap_go), .we(!rnw), .idx(ap_idx),
    .wdata(wd), .abort(abort_go), .busy(ap_busy), .done(ap_done),
    .rdata(ap_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) wait_q <= 1'b0;
    else if (tap_state == TS_CAP_DR) wait_q <= ap_busy;
  end

  always_ff @(posedge clk) begin
    if (rst || tap_state == TS_RESET) begin
      oren_q <= 1'b0;
      orun_q <= 1'b0;
      err_q  <= 1'b0;
      bank_q <= '0;
      apn_q  <= '0;
    end else begin
      if (upd && (is_dp || is_ap) && wait_q && oren_q) orun_q <= 1'b1;
      if (acc_ok && is_dp && !rnw) begin
        case (reg_a)
          2'd1: begin
            oren_q <= wd[0];
            if (wd[1]) orun_q <= 1'b0;
            if (wd[5]) err_q  <= 1'b0;
          end
          2'd2: begin
            bank_q <= wd[7:4];
            apn_q  <= wd[31:24];
          end
          default: ;
        endcase
      end
      if (ap_miss) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      post_q <= '0;
    end else begin
      if (ap_done) post_q <= ap_rdata;
      if (acc_ok && is_dp && rnw) begin
        case (reg_a)
          2'd0:    post_q <= '0;
          2'd1:    post_q <= ctrl_rd;
          2'd2:    post_q <= sel_rd;
          default: ;
        endcase
      end
      if (ap_miss && rnw) post_q <= '0;
    end
  end

  always_comb begin
    if (tap_state == TS_SHF_IR)      tdo = ir_tdo;
    else if (tap_state == TS_SHF_DR) tdo = dr_sr[0];
    else                             tdo = 1'b0;
  end

endmodule

// File: rtl/jdp_port_chk.sv
module jdp_port_chk
  import jdp_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            tms,
  input logic            tdo,
  input tap_state_t      state,
  input logic [IR_W-1:0] ir,
  input logic            orun,
  input logic            err,
  input logic [3:0]      bank,
  input logic [7:0]      apn,
  input logic            ap_busy
);

  assert_tlr_reach_R1: assert property (@(posedge clk) disable iff (rst)
    tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)
    |=> state == TS_RESET);

  assert_ir_default_R1: assert property (@(posedge clk) disable iff (rst)
    state == TS_RESET |=> ir == IR_IDCODE);

  assert_tlr_clears_R12: assert property (@(posedge clk) disable iff (rst)
    state == TS_RESET |=> !orun && !err && bank == 4'd0 && apn == 8'd0);

  assert_sticky_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    (orun || err) && !ap_busy |=> !ap_busy);

  assert_tdo_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    !(state == TS_SHF_IR || state == TS_SHF_DR) |-> tdo == 1'b0);

endmodule

bind jdp_port jdp_port_chk u_jdp_port_chk (
  .clk(clk), .rst(rst), .tms(tms), .tdo(tdo), .state(tap_state), .ir(ir_q),
  .orun(orun_q), .err(err_q), .bank(bank_q), .apn(apn_q), .ap_busy(ap_busy)
);

// File: tb/test_jdp_port.sv
module test_jdp_port;
  import jdp_pkg::*;

  localparam int          TCK_PERIOD = 10;
  localparam logic [31:0] ID         = 32'h4C6B_2A11;
  localparam int          LAT        = 60;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [3:0] pwr_ack = 4'hF;
  logic       tdo;

  jdp_port #(.IDCODE_VAL(ID), .AP_AW(6), .AP_LAT(LAT)) i_jdp_port (
    .clk(clk), .rst(rst), .tms(tms), .tdi(tdi), .pwr_ack(pwr_ack), .tdo(tdo)
  );

  always #(TCK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_post = '0, m_pend = '0;
  logic [31:0] m_mem [64];
  logic        m_rd = 0, m_oren = 0, m_orun = 0, m_err = 0;
  logic [3:0]  m_bank = '0;
  logic [7:0]  m_apn = '0;
  int          m_busy = 0;
  logic [3:0]  cur_ir = IR_IDCODE;

  function automatic logic [31:0] m_ctrl();
    return {pwr_ack, 22'd0, m_err, 3'd0, m_orun, m_oren};
  endfunction

  function automatic logic [31:0] m_sel();
    return {m_apn, 16'd0, m_bank, 4'd0};
  endfunction

  task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_dec();
    if (m_busy > 0) begin
      if (m_busy == 1 && m_rd) m_post = m_pend;
      m_busy--;
    end
  endtask

  task automatic tick(input logic t_ms, input logic t_di, output logic t_do, input bit nodec);
    t_do = tdo;
    tms  = t_ms;
    tdi  = t_di;
    @(posedge clk);
    #1;
    if (!nodec) model_dec();
  endtask

  task automatic idle(input int n);
    logic b;
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, b, 0);
  endtask

  task automatic go_tlr();
    logic b;
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, b, 0);
    m_orun = 0; m_err = 0; m_oren = 0; m_bank = '0; m_apn = '0;
    cur_ir = IR_IDCODE;
    chk("R13 tdo in reset state", {34'd0, tdo}, 35'd0);
    tick(1'b0, 1'b0, b, 0);
  endtask

  task automatic ir_scan(input logic [3:0] code, output logic [3:0] cap);
    logic b;
    tick(1'b1, 1'b0, b, 0);
    tick(1'b1, 1'b0, b, 0);
    tick(1'b0, 1'b0, b, 0);
    tick(1'b0, 1'b0, b, 0);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, code[i], b, 0);
      cap[i] = b;
    end
    tick(1'b1, 1'b0, b, 0);
    tick(1'b0, 1'b0, b, 0);
    cur_ir = code;
  endtask

  // leaves the final update edge to the caller when nodec is set
  task automatic dr_scan(input int len, input logic [34:0] din, input bit nodec,
                         output logic [34:0] dout, output bit cap_wait,
                         output logic [31:0] cap_post);
    logic b;
    dout = '0;
    tick(1'b1, 1'b0, b, 0);
    tick(1'b0, 1'b0, b, 0);
    cap_wait = (m_busy > 0);
    cap_post = m_post;
    tick(1'b0, 1'b0, b, 0);
    for (int i = 0; i < len; i++) begin
      tick(i == len - 1, din[i], b, 0);
      dout[i] = b;
    end
    tick(1'b1, 1'b0, b, 0);
    tick(1'b0, 1'b0, b, nodec);
  endtask

  task automatic model_upd(input logic [3:0] code, input logic [1:0] a, input logic rnw,
                           input logic [31:0] d, input bit w);
    bit started = 0, killed = 0;
    logic [5:0] idx;
    if (code == IR_ABORT) begin
      if (d == 32'd1) begin m_busy = 0; killed = 1; end
    end else if (w) begin
      if (m_oren) m_orun = 1;
    end else if (code == IR_DPACC) begin
      if (rnw) begin
        case (a)
          2'd0: m_post = '0;
          2'd1: m_post = m_ctrl();
          2'd2: m_post = m_sel();
          default: ;
        endcase
      end else begin
        case (a)
          2'd1: begin
            m_oren = d[0];
            if (d[1]) m_orun = 0;
            if (d[5]) m_err = 0;
          end
          2'd2: begin m_bank = d[7:4]; m_apn = d[31:24]; end
          default: ;
        endcase
      end
    end else if (!(m_orun || m_err)) begin
      if (m_apn != 0) begin
        m_err = 1;
        if (rnw) m_post = '0;
      end else begin
        idx = {m_bank, a};
        if (rnw) begin m_pend = m_mem[idx]; m_rd = 1; end
        else     begin m_mem[idx] = d; m_rd = 0; end
        m_busy  = LAT;
        started = 1;
      end
    end
    if (!started && !killed) model_dec();
  endtask

  task automatic access(input string tag, input logic [3:0] code, input logic [1:0] a,
                        input logic rnw, input logic [31:0] d,
                        output logic [2:0] ack, output logic [31:0] q);
    logic [3:0]  c;
    logic [34:0] dout;
    bit          w;
    logic [31:0] cp;
    if (cur_ir != code) ir_scan(code, c);
    dr_scan(35, {d, a, rnw}, 1, dout, w, cp);
    ack = dout[2:0];
    q   = dout[34:3];
    chk({"R3 ack ", tag}, {32'd0, ack}, {32'd0, w ? ACK_WAIT : ACK_OK});
    if (!w) chk({"R4 posted ", tag}, {3'd0, q}, {3'd0, cp});
    model_upd(code, a, rnw, d, w);
  endtask

  initial begin
    #(TCK_PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0]  ack;
    logic [31:0] q, old;
    logic [3:0]  c;
    logic [34:0] dout;
    bit          w;
    logic [31:0] cp;
    void'($urandom(32'd4711));

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk("R13 tdo after reset", {34'd0, tdo}, 35'd0);

    // R1: identification right after reset
    idle(1);
    dr_scan(32, 35'd0, 0, dout, w, cp);
    chk("R1 identification", dout, {3'd0, ID});

    // R2: instruction capture and bypass
    ir_scan(4'hF, c);
    chk("R2 ir capture", {31'd0, c}, {31'd0, IR_CAPVAL});
    dr_scan(2, 35'd1, 0, dout, w, cp);
    chk("R2 bypass", dout, 35'b10);
    chk("R13 tdo idle", {34'd0, tdo}, 35'd0);

    // fill the access-port register file through banks 0..3
    for (int b = 0; b < 4; b++) begin
      access("sel init", IR_DPACC, 2'd2, 0, {24'd0, b[3:0], 4'd0}, ack, q);
      for (int a = 0; a < 4; a++) begin
        access("ap init", IR_APACC, a[1:0], 0, 32'hA000_0000 + 32'(b * 4 + a), ack, q);
        idle(LAT + 5);
      end
    end

    // R5 / R4: control/status with power bits, then read buffer
    pwr_ack = 4'h5;
    access("ctrl rd", IR_DPACC, 2'd1, 1, 0, ack, q);
    access("rdbuff", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R5 ctrl power bits", {3'd0, q}, {3'd0, 4'h5, 28'd0});
    access("rdbuff again", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R4 rdbuff no side effect", {3'd0, q}, {3'd0, 4'h5, 28'd0});
    pwr_ack = 4'hF;

    // R6: select readback keeps only bank and port number
    access("sel wr", IR_DPACC, 2'd2, 0, 32'h00FF_FF2F, ack, q);
    access("sel rd", IR_DPACC, 2'd2, 1, 0, ack, q);
    access("rdbuff sel", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R6 select readback", {3'd0, q}, {3'd0, 32'h0000_0020});

    // R7 / R8: write then immediate read -> WAIT, request dropped, no overrun
    access("ap wr", IR_APACC, 2'd1, 0, 32'h1234_5678, ack, q);
    access("ap rd busy", IR_APACC, 2'd1, 1, 0, ack, q);
    chk("R7 busy gives wait", {32'd0, ack}, {32'd0, ACK_WAIT});
    idle(LAT);
    access("ap rd", IR_APACC, 2'd1, 1, 0, ack, q);
    idle(LAT + 2);
    access("rdbuff ap", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R7 read posted after busy", {3'd0, q}, {3'd0, 32'h1234_5678});
    access("ctrl rd", IR_DPACC, 2'd1, 1, 0, ack, q);
    access("rdbuff ctrl", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R8 no overrun when disabled", {33'd0, q[1:0]}, 35'd0);

    // R8: overrun detect on, dropped write, sticky overrun
    access("ctrl en", IR_DPACC, 2'd1, 0, 32'h1, ack, q);
    access("ap wr a", IR_APACC, 2'd2, 0, 32'hAAAA_0001, ack, q);
    access("ap wr drop", IR_APACC, 2'd3, 0, 32'hDEAD_0003, ack, q);
    chk("R8 second write waits", {32'd0, ack}, {32'd0, ACK_WAIT});
    idle(LAT);
    access("ctrl rd", IR_DPACC, 2'd1, 1, 0, ack, q);
    access("rdbuff ctrl", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R8 sticky overrun set", {33'd0, q[1:0]}, 35'd3);

    // R9: sticky set -> AP write and read discarded
    old = m_post;
    access("ap wr sticky", IR_APACC, 2'd0, 0, 32'hBAD0_BAD0, ack, q);
    access("ap rd sticky", IR_APACC, 2'd0, 1, 0, ack, q);
    chk("R9 no wait while sticky", {32'd0, ack}, {32'd0, ACK_OK});
    access("rdbuff sticky", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R9 posted unchanged", {3'd0, q}, {3'd0, old});
    access("ctrl clr", IR_DPACC, 2'd1, 0, 32'h2, ack, q);
    access("ap rd 3", IR_APACC, 2'd3, 1, 0, ack, q);
    idle(LAT + 2);
    access("rdbuff", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R8 dropped write kept old value", {3'd0, q}, {3'd0, 32'hA000_000B});
    access("ap rd 0", IR_APACC, 2'd0, 1, 0, ack, q);
    idle(LAT + 2);
    access("rdbuff", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R9 discarded write", {3'd0, q}, {3'd0, 32'hA000_0008});

    // R10: non-zero port number sets sticky error and posts zero
    access("sel ap3", IR_DPACC, 2'd2, 0, 32'h0300_0020, ack, q);
    access("ap miss", IR_APACC, 2'd1, 1, 0, ack, q);
    access("rdbuff miss", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R10 miss posts zero", {3'd0, q}, 35'd0);
    access("ctrl rd", IR_DPACC, 2'd1, 1, 0, ack, q);
    access("rdbuff ctrl", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R10 sticky error set", {34'd0, q[5]}, 35'd1);
    access("ctrl clr", IR_DPACC, 2'd1, 0, 32'h20, ack, q);
    access("sel ap0", IR_DPACC, 2'd2, 0, 32'h0000_0010, ack, q);

    // R11: abort with value 1 cancels the pending read
    access("ctrl rd", IR_DPACC, 2'd1, 1, 0, ack, q);
    old = m_post;
    access("ap rd abort", IR_APACC, 2'd2, 1, 0, ack, q);
    access("abort 1", IR_ABORT, 2'd0, 0, 32'd1, ack, q);
    access("rdbuff post abort", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R11 ok after abort", {32'd0, ack}, {32'd0, ACK_OK});
    chk("R11 read never posted", {3'd0, q}, {3'd0, old});
    access("ap rd noabort", IR_APACC, 2'd2, 1, 0, ack, q);
    access("abort 0", IR_ABORT, 2'd0, 0, 32'd0, ack, q);
    idle(LAT);
    access("rdbuff", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R11 other value no effect", {3'd0, q}, {3'd0, 32'hA000_0006});

    // R12: Test-Logic-Reset clears flags and select
    access("ctrl set", IR_DPACC, 2'd1, 0, 32'h1, ack, q);
    access("sel set", IR_DPACC, 2'd2, 0, 32'h0700_0030, ack, q);
    access("ap miss", IR_APACC, 2'd0, 1, 0, ack, q);
    go_tlr();
    access("ctrl rd", IR_DPACC, 2'd1, 1, 0, ack, q);
    access("sel rd", IR_DPACC, 2'd2, 1, 0, ack, q);
    chk("R12 ctrl cleared", {3'd0, q}, {3'd0, 4'hF, 28'd0});
    access("rdbuff", IR_DPACC, 2'd3, 1, 0, ack, q);
    chk("R12 select cleared", {3'd0, q}, 35'd0);

    // constrained random traffic against the model
    for (int n = 0; n < 260; n++) begin
      int r;
      logic [3:0] rb;
      r  = $urandom % 8;
      rb = 4'($urandom % 4);
      if (r < 5) begin
        if (rb != m_bank) access("rnd sel", IR_DPACC, 2'd2, 0, {24'd0, rb, 4'd0}, ack, q);
        access("rnd ap", IR_APACC, 2'($urandom % 4), r < 3, $urandom, ack, q);
      end else if (r == 5) begin
        access("rnd ctrl rd", IR_DPACC, 2'd1, 1, 0, ack, q);
      end else if (r == 6) begin
        access("rnd rdbuff", IR_DPACC, 2'd3, 1, 0, ack, q);
      end else begin
        access("rnd ctrl wr", IR_DPACC, 2'd1, 0,
               {26'd0, 1'($urandom), 3'd0, 1'($urandom), 1'($urandom)}, ack, q);
      end
      idle($urandom % 80);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule